// File: doc/BRIEF.md
# Reference Frequency Window Monitor

This block judges whether a reference clock runs close enough to its nominal rate, and whether a divided feedback clock tracks that reference. It counts single-cycle edge pulses from the reference and the feedback over a fixed gate period of a stable timebase. At the end of each gate period it captures both counts. In the following cycle it updates two decisions, each with its own hysteresis band.

The first decision, `freq_ok`, checks the reference count against a nominal count. A tight band turns the flag on and a much wider band turns it off. The second decision, `lock_n`, is active low. It compares the reference count with the feedback count at parts-per-million resolution, again with separate enter and exit limits. The two paths share only the captured reference count, and the lock result never feeds the qualification decision. A controller that has entered holdover raises `holdover`, which forces the lock flag to its unlocked level.

The edge inputs are assumed to be synchronized to the timebase, with at most one pulse per cycle. Every threshold is a parameter given in ppm and is turned into a count bound inside the block.

Top module: `freq_window_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `freq_ok` becomes 0 and `lock_n` becomes 1.
- R2: Each input counts its pulses over every run of GATE_CYCLES timebase cycles. The first run starts at the first edge with reset released. Both decisions update only in the cycle after a run ends, and otherwise hold their values. A captured count never exceeds GATE_CYCLES.
- R3: `freq_ok` becomes 1 when the reference count R is nonzero and |R − NOM_COUNT| ≤ floor(NOM_COUNT·QUAL_IN_PPM/10^6). With the defaults this is a ±2.4 % band.
- R4: `freq_ok` becomes 0 when |R − NOM_COUNT| > floor(NOM_COUNT·QUAL_OUT_PPM/10^6). With the defaults this is a ±8 % band.
- R5: When the deviation lies between the two qualification bounds, `freq_ok` keeps its previous value.
- R6: A reference count of zero in a gate period clears `freq_ok`.
- R7: Let F be the feedback count. `lock_n` becomes 0 (locked) when R is nonzero and |R − F|·10^6 ≤ LOCK_IN_PPM·R. The default is 500 ppm.
- R8: `lock_n` becomes 1 (unlocked) when |R − F|·10^6 > LOCK_OUT_PPM·R, or when R is zero. The default is 800 ppm.
- R9: Between the two lock limits, `lock_n` keeps its previous value.
- R10: A cycle with `holdover` high sets `lock_n` to 1 at the next edge. `lock_n` stays 1 while `holdover` is high and until the next gate evaluation after `holdover` falls.
- R11: `freq_ok` depends only on the reference count. A feedback count far from the reference does not clear it, and a disqualified reference does not by itself unlock `lock_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per reference edge, synchronized to clk |
| fb_pulse | input | 1 | One-cycle pulse per divided feedback edge, synchronized to clk |
| holdover | input | 1 | High while the switching controller is in holdover |
| freq_ok | output | 1 | Reference frequency qualified |
| lock_n | output | 1 | Active-low lock indication |

## Verification
The bench drives pulse trains that hold an exact count per gate whatever the gate alignment. It steps the counts across each edge of both hysteresis bands. It probes one count inside each band edge and one count just beyond it: 4096 and 4097 against 96 allowed, 4320 and 4321 against 320, and differences of 2, 3 and 4 against the 500/800 ppm window. A design that uses `<` where `<=` belongs, or that forgets the hold state, flips on the wrong one of these counts. A zero reference count must disqualify at once and must not read as a perfect lock. The bench also checks that a holdover released mid-gate keeps the lock flag high until the next evaluation, and that every change of `freq_ok` falls on the gate boundary. A feedback mismatch with a good reference, and the reverse, catch any coupling between the two decisions.

// File: rtl/freqmon_pkg.sv
// Shared definitions for the frequency window monitor.
// Assumes: thresholds are expressed in parts per million of a count.
package freqmon_pkg;

    // Scale of a ppm threshold.
    localparam longint unsigned PPM_SCALE = 64'd1_000_000;

    // Where a measurement falls against a hysteresis pair.
    typedef enum logic [1:0] {
        BAND_INSIDE  = 2'd0,
        BAND_BETWEEN = 2'd1,
        BAND_OUTSIDE = 2'd2
    } band_e;

    // Next state of a hysteretic flag: set inside, clear outside, hold between.
    function automatic logic band_next(band_e band, logic prev);
        case (band)
            BAND_INSIDE:  band_next = 1'b1;
            BAND_OUTSIDE: band_next = 1'b0;
            default:      band_next = prev;
        endcase
    endfunction

endpackage

// File: rtl/freqmon_gate_timer.sv
// Gate timer: counts timebase cycles and marks the last cycle of each gate.
// Assumes: GATE_CYCLES >= 2; the first gate starts at the first edge out of reset.
module freqmon_gate_timer #(
    parameter int GATE_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end
);
    localparam int TMR_W = $clog2(GATE_CYCLES);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(GATE_CYCLES - 1);

    logic [TMR_W-1:0] tick;

    // Flag the final cycle of the current gate.
    always_comb gate_end = (tick == LAST);

    // Advance the cycle position, wrapping at the gate length.
    always_ff @(posedge clk) begin
        if (!rst_n)        tick <= '0;
        else if (gate_end) tick <= '0;
        else               tick <= tick + 1'b1;
    end
endmodule

// File: rtl/freqmon_edge_counter.sv
// Edge counter: accumulates one-cycle pulses and captures the total per gate.
// Assumes: at most one pulse per cycle, so a count never exceeds the gate length.
module freqmon_edge_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             gate_end,
    output logic [CNT_W-1:0] count,
    output logic             count_vld
);
    logic [CNT_W-1:0] running;

    // Accumulate pulses; on the last gate cycle capture the total, including that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= '0;
            count     <= '0;
            count_vld <= 1'b0;
        end else if (gate_end) begin
            count     <= running + CNT_W'(pulse);
            running   <= '0;
            count_vld <= 1'b1;
        end else begin
            running   <= running + CNT_W'(pulse);
            count_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/freqmon_qualifier.sv
// Frequency qualifier: hysteretic check of the reference count against nominal.
// Assumes: NOM_COUNT <= 2**CNT_W - 1 and QUAL_IN_PPM <= QUAL_OUT_PPM.
module freqmon_qualifier
    import freqmon_pkg::*;
#(
    parameter int CNT_W        = 17,
    parameter int NOM_COUNT    = 60000,
    parameter int QUAL_IN_PPM  = 24000,
    parameter int QUAL_OUT_PPM = 80000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_vld,
    input  logic [CNT_W-1:0] ref_count,
    output logic             freq_ok
);
    localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOM_COUNT);
    localparam longint unsigned ENTER_DEV =
        (longint'(NOM_COUNT) * longint'(QUAL_IN_PPM)) / PPM_SCALE;
    localparam longint unsigned LEAVE_DEV =
        (longint'(NOM_COUNT) * longint'(QUAL_OUT_PPM)) / PPM_SCALE;

    logic [CNT_W-1:0] dev;
    band_e            band;

    // Absolute distance of the measured count from nominal.
    always_comb dev = (ref_count >= NOM_C) ? (ref_count - NOM_C) : (NOM_C - ref_count);

    // Classify the distance; a silent reference is always outside.
    always_comb begin
        if (ref_count == '0)                  band = BAND_OUTSIDE;
        else if (64'(dev) <= 64'(ENTER_DEV))  band = BAND_INSIDE;
        else if (64'(dev) >  64'(LEAVE_DEV))  band = BAND_OUTSIDE;
        else                                  band = BAND_BETWEEN;
    end

    // Update the qualification flag once per captured measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)        freq_ok <= 1'b0;
        else if (meas_vld) freq_ok <= band_next(band, freq_ok);
    end
endmodule

// File: rtl/freqmon_lock_detect.sv
// Lock detector: hysteretic ppm comparison of feedback count against reference count.
// Assumes: counts come from the same gate; holdover overrides every evaluation.
module freqmon_lock_detect
    import freqmon_pkg::*;
#(
    parameter int CNT_W        = 17,
    parameter int LOCK_IN_PPM  = 500,
    parameter int LOCK_OUT_PPM = 800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_vld,
    input  logic             holdover,
    input  logic [CNT_W-1:0] ref_count,
    input  logic [CNT_W-1:0] fb_count,
    output logic             lock_n
);
    localparam logic [63:0] ENTER_K = 64'(LOCK_IN_PPM);
    localparam logic [63:0] LEAVE_K = 64'(LOCK_OUT_PPM);

    logic [CNT_W-1:0] gap;
    logic [63:0]      gap_scaled;
    logic [63:0]      enter_lim;
    logic [63:0]      leave_lim;
    band_e            band;

    // Distance between the two counts, scaled to ppm units.
    always_comb begin
        gap        = (ref_count >= fb_count) ? (ref_count - fb_count) : (fb_count - ref_count);
        gap_scaled = 64'(gap) * PPM_SCALE;
        enter_lim  = 64'(ref_count) * ENTER_K;
        leave_lim  = 64'(ref_count) * LEAVE_K;
    end

    // Classify the scaled distance; no reference means no lock.
    always_comb begin
        if (ref_count == '0)             band = BAND_OUTSIDE;
        else if (gap_scaled <= enter_lim) band = BAND_INSIDE;
        else if (gap_scaled >  leave_lim) band = BAND_OUTSIDE;
        else                              band = BAND_BETWEEN;
    end

    // Active-low lock flag: forced high in holdover, else updated per measurement.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_n <= 1'b1;
        else if (holdover) lock_n <= 1'b1;
        else if (meas_vld) lock_n <= ~band_next(band, ~lock_n);
    end
endmodule

// File: rtl/freq_window_monitor.sv
// Frequency window monitor top: gate timer, two edge counters, qualifier and lock detector.
// Assumes: pulse inputs are synchronized to clk with at most one pulse per cycle.
module freq_window_monitor #(
    parameter int GATE_CYCLES  = 65536,
    parameter int NOM_COUNT    = 60000,
    parameter int QUAL_IN_PPM  = 24000,
    parameter int QUAL_OUT_PPM = 80000,
    parameter int LOCK_IN_PPM  = 500,
    parameter int LOCK_OUT_PPM = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_pulse,
    input  logic fb_pulse,
    input  logic holdover,
    output logic freq_ok,
    output logic lock_n
);
    localparam int CNT_W = $clog2(GATE_CYCLES + 1);
    localparam int N_CH  = 2;

    logic             gate_end;
    logic [N_CH-1:0]  pulses;
    logic [N_CH-1:0]  cnt_vld;
    logic [CNT_W-1:0] counts [N_CH];
    logic [CNT_W-1:0] ref_count;
    logic [CNT_W-1:0] fb_count;
    logic             meas_vld;

    // Gather the pulse inputs: channel 0 reference, channel 1 feedback.
    always_comb pulses = {fb_pulse, ref_pulse};

    freqmon_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_end (gate_end)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        freqmon_edge_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .pulse     (pulses[ch]),
            .gate_end  (gate_end),
            .count     (counts[ch]),
            .count_vld (cnt_vld[ch])
        );
    end

    // Name the captured counts and their shared valid strobe.
    always_comb begin
        ref_count = counts[0];
        fb_count  = counts[1];
        meas_vld  = &cnt_vld;
    end

    freqmon_qualifier #(
        .CNT_W        (CNT_W),
        .NOM_COUNT    (NOM_COUNT),
        .QUAL_IN_PPM  (QUAL_IN_PPM),
        .QUAL_OUT_PPM (QUAL_OUT_PPM)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_vld  (meas_vld),
        .ref_count (ref_count),
        .freq_ok   (freq_ok)
    );

    freqmon_lock_detect #(
        .CNT_W        (CNT_W),
        .LOCK_IN_PPM  (LOCK_IN_PPM),
        .LOCK_OUT_PPM (LOCK_OUT_PPM)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_vld  (meas_vld),
        .holdover  (holdover),
        .ref_count (ref_count),
        .fb_count  (fb_count),
        .lock_n    (lock_n)
    );
endmodule

// File: rtl/freqmon_checker.sv
// Property checker for the frequency window monitor, attached by bind.
// Assumes: observes the captured reference count and its valid strobe inside the top.
module freqmon_checker #(
    parameter int CNT_W       = 17,
    parameter int GATE_CYCLES = 65536
) (
    input logic             clk,
    input logic             rst_n,
    input logic             holdover,
    input logic             meas_vld,
    input logic [CNT_W-1:0] ref_count,
    input logic             freq_ok,
    input logic             lock_n
);
    // R2: qualification changes only after a captured measurement.
    assert_qual_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_vld |=> $stable(freq_ok));

    // R2: lock flag changes only after a measurement or holdover.
    assert_lock_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_vld && !holdover) |=> $stable(lock_n));

    // R2: a captured count never exceeds the gate length.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        meas_vld |-> (ref_count <= CNT_W'(GATE_CYCLES)));

    // R6: an empty gate disqualifies the reference.
    assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && ref_count == '0) |=> !freq_ok);

    // R8: an empty gate never reports lock.
    assert_zero_nolock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_vld && ref_count == '0) |=> lock_n);

    // R10: holdover forces the unlocked level.
    assert_holdover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        holdover |=> lock_n);
endmodule

bind freq_window_monitor freqmon_checker #(
    .CNT_W       (CNT_W),
    .GATE_CYCLES (GATE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .holdover  (holdover),
    .meas_vld  (meas_vld),
    .ref_count (ref_count),
    .freq_ok   (freq_ok),
    .lock_n    (lock_n)
);

// File: tb/freq_window_monitor_tb.sv
// Directed bench for the frequency window monitor; one task per scenario.
module freq_window_monitor_tb;
    localparam int G   = 4400;
    localparam int NOM = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0;
    logic fb_pulse = 1'b0;
    logic holdover = 1'b0;
    logic freq_ok;
    logic lock_n;

    int n_checks = 0;
    int n_fail = 0;
    int ref_rate = 0;
    int fb_rate = 0;
    int acc_r = 0;
    int acc_f = 0;
    int edge_idx = 0;
    int misaligned = 0;
    int ok_changes = 0;
    logic prev_ok = 1'b0;

    freq_window_monitor #(
        .GATE_CYCLES (G),
        .NOM_COUNT   (NOM)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse),
        .holdover  (holdover),
        .freq_ok   (freq_ok),
        .lock_n    (lock_n)
    );

    always #10 clk = ~clk;

    // Pulse trains with exactly rate pulses in any G consecutive cycles.
    always @(negedge clk) begin
        acc_r = acc_r + ref_rate;
        if (acc_r >= G) begin ref_pulse <= 1'b1; acc_r = acc_r - G; end
        else ref_pulse <= 1'b0;
        acc_f = acc_f + fb_rate;
        if (acc_f >= G) begin fb_pulse <= 1'b1; acc_f = acc_f - G; end
        else fb_pulse <= 1'b0;
    end

    // Count edges since reset release.
    always @(posedge clk) edge_idx <= rst_n ? edge_idx + 1 : 0;

    // R2 monitor: freq_ok may change only at the gate boundary.
    always @(negedge clk) begin
        if (rst_n && freq_ok !== prev_ok) begin
            ok_changes++;
            if (((edge_idx - 1) % G) != 0) misaligned++;
        end
        prev_ok = freq_ok;
    end

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic settle(input int r, input int f);
        @(negedge clk);
        ref_rate = r;
        fb_rate = f;
        repeat (2 * G + 4) @(negedge clk);
    endtask

    task automatic t_reset();
        ref_rate = NOM;
        fb_rate = NOM;
        repeat (5) @(negedge clk);
        check(freq_ok, 1'b0, "R1", "freq_ok in reset");
        check(lock_n, 1'b1, "R1", "lock_n in reset");
        rst_n = 1'b1;
        repeat (G - 5) @(negedge clk);
        check(freq_ok, 1'b0, "R2", "freq_ok before first evaluation");
        check(lock_n, 1'b1, "R2", "lock_n before first evaluation");
        repeat (10) @(negedge clk);
        check(freq_ok, 1'b1, "R3", "nominal reference qualified");
        check(lock_n, 1'b0, "R7", "matched feedback locks");
    endtask

    task automatic t_lock_band();
        settle(NOM, NOM + 3);
        check(lock_n, 1'b0, "R9", "3 counts apart stays locked");
        settle(NOM, NOM + 4);
        check(lock_n, 1'b1, "R8", "4 counts apart unlocks");
        check(freq_ok, 1'b1, "R11", "feedback error keeps qualification");
        settle(NOM, NOM + 3);
        check(lock_n, 1'b1, "R9", "3 counts apart stays unlocked");
        settle(NOM, NOM - 2);
        check(lock_n, 1'b0, "R7", "2 counts apart relocks");
    endtask

    task automatic t_qual_band();
        settle(4320, 4320);
        check(freq_ok, 1'b1, "R5", "deviation 320 holds qualified");
        settle(4321, 4321);
        check(freq_ok, 1'b0, "R4", "deviation 321 disqualifies");
        check(lock_n, 1'b0, "R11", "disqualified reference still locked");
        settle(4097, 4097);
        check(freq_ok, 1'b0, "R5", "deviation 97 holds disqualified");
        settle(3904, 3904);
        check(freq_ok, 1'b1, "R3", "deviation 96 requalifies");
    endtask

    task automatic t_zero();
        settle(0, NOM);
        check(freq_ok, 1'b0, "R6", "zero count disqualifies");
        check(lock_n, 1'b1, "R8", "zero count unlocks");
        settle(NOM, NOM);
        check(freq_ok, 1'b1, "R3", "recovery after zero count");
        check(lock_n, 1'b0, "R7", "relock after zero count");
    endtask

    task automatic t_independent();
        settle(NOM, 3000);
        check(freq_ok, 1'b1, "R11", "far feedback leaves qualification set");
        check(lock_n, 1'b1, "R8", "far feedback unlocks");
        settle(NOM, NOM);
        check(lock_n, 1'b0, "R7", "relock after far feedback");
    endtask

    task automatic t_holdover();
        @(negedge clk);
        holdover = 1'b1;
        repeat (3) @(negedge clk);
        check(lock_n, 1'b1, "R10", "holdover forces unlock");
        repeat (2 * G) @(negedge clk);
        check(lock_n, 1'b1, "R10", "unlock held across evaluations");
        while (((edge_idx - 1) % G) != G / 2) @(negedge clk);
        holdover = 1'b0;
        repeat (2) @(negedge clk);
        check(lock_n, 1'b1, "R10", "unlock held until next evaluation");
        repeat (G) @(negedge clk);
        check(lock_n, 1'b0, "R10", "relock after holdover");
    endtask

    initial begin
        t_reset();
        t_lock_band();
        t_qual_band();
        t_zero();
        t_independent();
        t_holdover();
        n_checks++;
        if (misaligned != 0 || ok_changes == 0) begin
            n_fail++;
            $display("FAIL R2 freq_ok change alignment: actual %0d misaligned of %0d expected 0 of >0",
                     misaligned, ok_changes);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule